// File: doc/BRIEF.md
# Atomic Section Ownership Gate

This block stands in front of a request tracker that is shared by several requesting processors. It serializes read-modify-write sequences. One register holds the ID of the processor that owns the current atomic section, or a reserved idle code when no section is open. A counter records how many atomic reads from that owner still wait for a matching atomic-write completion.

Each cycle the block judges one candidate request and answers with a combinational grant. Ownership changes only when a grant is actually taken. A probe flag asks for the verdict alone and leaves all state untouched. Completions of atomic writes come in on a separate port. They unwind the nesting count and release ownership when the count reaches zero. A completion that breaks the protocol sets a sticky error flag.

Top module: `atomic_gate`

## Requirements
- R1: After reset the owner is idle (`owner_busy`=0, `owner_pid` equal to the idle code, which is all ones), `nest_cnt` is 0 and `proto_err` is 0.
- R2: A taken request of kind 1 (atomic read) is granted while idle. It makes the requester the owner and sets the count to 1.
- R3: While a section is owned, every request whose ID differs from the owner is stalled, whatever its kind.
- R4: A taken atomic read from the owner increments the count and keeps the owner.
- R5: A taken request from the owner of kind 0 or 3 (plain access) closes the section: the owner goes idle and the count returns to 0. A kind-2 request (atomic write) from the owner is granted and changes nothing.
- R6: A completion whose ID is the owner's, with a nonzero count, decrements the count. When the count reaches 0 the owner becomes idle.
- R7: A request with `req_probe`=1 returns the same grant verdict as a taken request but leaves the owner and the count unchanged.
- R8: A completion from a non-owner, or one that arrives while the count is 0, sets `proto_err`. The flag stays set until reset, and that completion changes no other state.
- R9: An atomic read is stalled when the count is at its maximum, 2^CNT_W-1.
- R10: A request that carries the idle code as its ID is always stalled.
- R11: While idle, a plain access from any valid ID is granted and leaves the state idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A candidate request is present |
| req_pid | input | PID_W | Requesting processor ID |
| req_kind | input | 2 | 0 plain, 1 atomic read, 2 atomic write, 3 plain |
| req_probe | input | 1 | Query only: do not update state |
| req_grant | output | 1 | Request accepted this cycle |
| done_valid | input | 1 | Atomic-write completion strobe |
| done_pid | input | PID_W | ID that the completion belongs to |
| owner_busy | output | 1 | An atomic section is open |
| owner_pid | output | PID_W | Current owner ID, or the idle code |
| nest_cnt | output | CNT_W | Outstanding atomic reads of the owner |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The properties that compare state before and after a probe, or that check a claim, assume no completion arrives in the same cycle, and both are disabled when one does. They also assume that a valid request never carries the idle code unless it is meant to be stalled. The stimulus never pairs a completion with a request in one cycle. It issues an idle-code request only in the one test for R10. A reference model in the bench follows every step, including the completions from non-owners that the error check needs.

// File: rtl/atomic_gate_pkg.sv
package atomic_gate_pkg;
  typedef enum logic [1:0] {
    KIND_PLAIN  = 2'd0,
    KIND_RMW_RD = 2'd1,
    KIND_RMW_WR = 2'd2,
    KIND_ALT    = 2'd3
  } req_kind_e;
endpackage

// File: rtl/atomic_gate_judge.sv
module atomic_gate_judge
  import atomic_gate_pkg::*;
#(
  parameter int PID_W = 4,
  parameter int CNT_W = 3
) (
  input  logic [PID_W-1:0] own_q,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [PID_W-1:0] pid,
  input  logic [1:0]       kind,
  output logic             ok,
  output logic             from_owner
);
  localparam logic [PID_W-1:0] IDLE_ID = {PID_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic idle, pid_bad, foreign, full;

  always_comb begin
    idle       = (own_q == IDLE_ID);
    pid_bad    = (pid == IDLE_ID);
    from_owner = !idle && (pid == own_q);
    foreign    = !idle && !from_owner;
    full       = (kind == KIND_RMW_RD) && (cnt_q == CNT_MAX);
    ok         = !pid_bad && !foreign && !full;
  end
endmodule

// File: rtl/atomic_gate_state.sv
module atomic_gate_state
  import atomic_gate_pkg::*;
#(
  parameter int PID_W = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [PID_W-1:0] pid,
  input  logic [1:0]       kind,
  input  logic             from_owner,
  input  logic             done_valid,
  input  logic [PID_W-1:0] done_pid,
  output logic [PID_W-1:0] own_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             err_q
);
  localparam logic [PID_W-1:0] IDLE_ID = {PID_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [PID_W-1:0] own_d;
  logic [CNT_W-1:0] cnt_d;
  logic             err_d;
  logic             upd_en;
  logic             done_ok;

  always_comb begin
    done_ok = done_valid && (own_q != IDLE_ID) && (done_pid == own_q)
              && (cnt_q != '0);
    upd_en  = done_valid || take;
    own_d   = own_q;
    cnt_d   = cnt_q;
    err_d   = err_q || (done_valid && !done_ok);
    if (done_ok) begin
      cnt_d = cnt_q - CNT_ONE;
      if (cnt_q == CNT_ONE) own_d = IDLE_ID;
    end
    if (take) begin
      if (kind == KIND_RMW_RD) begin
        own_d = pid;
        cnt_d = cnt_d + CNT_ONE;
      end else if (kind != KIND_RMW_WR && from_owner) begin
        own_d = IDLE_ID;
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= IDLE_ID;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (upd_en) begin
      own_q <= own_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/atomic_gate.sv
module atomic_gate
  import atomic_gate_pkg::*;
#(
  parameter int PID_W = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [PID_W-1:0] req_pid,
  input  logic [1:0]       req_kind,
  input  logic             req_probe,
  output logic             req_grant,
  input  logic             done_valid,
  input  logic [PID_W-1:0] done_pid,
  output logic             owner_busy,
  output logic [PID_W-1:0] owner_pid,
  output logic [CNT_W-1:0] nest_cnt,
  output logic             proto_err
);
  localparam logic [PID_W-1:0] IDLE_ID = {PID_W{1'b1}};

  logic [PID_W-1:0] own_q;
  logic [CNT_W-1:0] cnt_q;
  logic             err_q;
  logic             ok, from_owner, take;

  atomic_gate_judge #(.PID_W(PID_W), .CNT_W(CNT_W)) u_judge (
    .own_q(own_q), .cnt_q(cnt_q), .pid(req_pid), .kind(req_kind),
    .ok(ok), .from_owner(from_owner)
  );

  assign take = req_valid && ok && !req_probe;

  atomic_gate_state #(.PID_W(PID_W), .CNT_W(CNT_W)) u_state (
    .clk(clk), .rst_n(rst_n), .take(take), .pid(req_pid), .kind(req_kind),
    .from_owner(from_owner), .done_valid(done_valid), .done_pid(done_pid),
    .own_q(own_q), .cnt_q(cnt_q), .err_q(err_q)
  );

  assign req_grant  = req_valid && ok;
  assign owner_busy = (own_q != IDLE_ID);
  assign owner_pid  = own_q;
  assign nest_cnt   = cnt_q;
  assign proto_err  = err_q;
endmodule

// File: rtl/atomic_gate_chk.sv
module atomic_gate_chk #(
  parameter int PID_W = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [PID_W-1:0] req_pid,
  input logic [1:0]       req_kind,
  input logic             req_probe,
  input logic             req_grant,
  input logic             done_valid,
  input logic [PID_W-1:0] done_pid,
  input logic             owner_busy,
  input logic [PID_W-1:0] owner_pid,
  input logic [CNT_W-1:0] nest_cnt,
  input logic             proto_err
);
  p_foreign_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && owner_busy && req_pid != owner_pid) |-> !req_grant);

  p_busy_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    owner_busy |-> (nest_cnt != '0));

  p_idle_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !owner_busy |-> (nest_cnt == '0));

  p_probe_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_probe && !done_valid)
      |=> ($stable(owner_pid) && $stable(nest_cnt)));

  p_claim_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_grant && !req_probe && req_kind == 2'd1 && !done_valid)
      |=> (owner_busy && owner_pid == $past(req_pid)));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
endmodule

bind atomic_gate atomic_gate_chk #(.PID_W(PID_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pid(req_pid),
  .req_kind(req_kind), .req_probe(req_probe), .req_grant(req_grant),
  .done_valid(done_valid), .done_pid(done_pid), .owner_busy(owner_busy),
  .owner_pid(owner_pid), .nest_cnt(nest_cnt), .proto_err(proto_err)
);

// File: tb/atomic_gate_bench.sv
`timescale 1ns/1ps
module atomic_gate_bench;
  localparam int PID_W = 4;
  localparam int CNT_W = 3;
  localparam logic [3:0] IDLE = 4'hF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_probe = 1'b0, done_valid = 1'b0;
  logic [3:0] req_pid = '0, done_pid = '0;
  logic [1:0] req_kind = '0;
  logic req_grant, owner_busy, proto_err;
  logic [3:0] owner_pid;
  logic [2:0] nest_cnt;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  atomic_gate #(.PID_W(PID_W), .CNT_W(CNT_W)) u_atomic_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pid(req_pid),
    .req_kind(req_kind), .req_probe(req_probe), .req_grant(req_grant),
    .done_valid(done_valid), .done_pid(done_pid), .owner_busy(owner_busy),
    .owner_pid(owner_pid), .nest_cnt(nest_cnt), .proto_err(proto_err)
  );

  typedef struct {
    logic       g;
    logic [3:0] own;
    logic [2:0] cnt;
    logic       err;
    string      tag;
  } exp_t;
  exp_t sb[$];

  logic [3:0] m_own = IDLE;
  logic [2:0] m_cnt = '0;
  logic       m_err = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [3:0] pid, input logic [1:0] kind,
                      input logic probe, input logic dv, input logic [3:0] dpid,
                      input string tag);
    exp_t e;
    logic g, owner_req;
    @(negedge clk);
    req_valid = v; req_pid = pid; req_kind = kind; req_probe = probe;
    done_valid = dv; done_pid = dpid;
    g = v && pid != IDLE && (m_own == IDLE || pid == m_own) && !(kind == 2'd1 && m_cnt == 3'd7);
    owner_req = (m_own != IDLE) && (pid == m_own);
    if (dv) begin
      if (m_own != IDLE && dpid == m_own && m_cnt != 0) begin
        m_cnt = m_cnt - 3'd1;
        if (m_cnt == 0) m_own = IDLE;
      end else m_err = 1'b1;
    end
    if (g && !probe) begin
      if (kind == 2'd1) begin m_own = pid; m_cnt = m_cnt + 3'd1; end
      else if (kind != 2'd2 && owner_req) begin m_own = IDLE; m_cnt = 0; end
    end
    e.g = g; e.own = m_own; e.cnt = m_cnt; e.err = m_err; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic quiet();
    @(negedge clk);
    req_valid = 0; done_valid = 0; req_probe = 0;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #3;
      if (sb.size() != 0) begin
        e = sb.pop_front();
        check(req_grant === e.g, {e.tag, " grant"}, req_grant, e.g);
        @(posedge clk);
        #1;
        check(owner_pid === e.own, {e.tag, " owner"}, owner_pid, e.own);
        check(nest_cnt === e.cnt, {e.tag, " count"}, nest_cnt, e.cnt);
        check(proto_err === e.err, {e.tag, " err"}, proto_err, e.err);
      end
    end
  end

  initial begin : watchdog
    #(8 * 20000);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    #20;
    rst_n = 1'b1;
    @(negedge clk);
    check(owner_busy === 1'b0, "R1 busy", owner_busy, 0);
    check(owner_pid === IDLE, "R1 owner", owner_pid, IDLE);
    check(nest_cnt === 3'd0, "R1 count", nest_cnt, 0);
    check(proto_err === 1'b0, "R1 err", proto_err, 0);

    step(1, 4'd2, 2'd0, 0, 0, 0, "R11 plain idle");
    step(1, 4'd3, 2'd3, 0, 0, 0, "R11 alt idle");
    step(1, IDLE, 2'd1, 0, 0, 0, "R10 idle id");
    step(1, 4'd5, 2'd1, 1, 0, 0, "R7 probe idle");
    step(1, 4'd5, 2'd1, 0, 0, 0, "R2 claim");
    step(1, 4'd6, 2'd1, 0, 0, 0, "R3 foreign rmw");
    step(1, 4'd6, 2'd0, 0, 0, 0, "R3 foreign plain");
    step(1, 4'd5, 2'd1, 0, 0, 0, "R4 nest");
    step(1, 4'd5, 2'd2, 0, 0, 0, "R5 owner write req");
    step(1, 4'd5, 2'd0, 1, 0, 0, "R7 probe owner");
    step(0, 0, 2'd0, 0, 1, 4'd5, "R6 done dec");
    step(0, 0, 2'd0, 0, 1, 4'd5, "R6 done release");
    step(1, 4'd6, 2'd1, 0, 0, 0, "R2 reclaim");
    step(1, 4'd6, 2'd1, 0, 0, 0, "R4 nest2");
    step(1, 4'd6, 2'd0, 0, 0, 0, "R5 abandon");
    step(1, 4'd7, 2'd1, 0, 0, 0, "R2 claim 7");
    for (int i = 0; i < 6; i++) step(1, 4'd7, 2'd1, 0, 0, 0, "R4 fill");
    step(1, 4'd7, 2'd1, 0, 0, 0, "R9 saturated");
    step(1, 4'd7, 2'd1, 1, 0, 0, "R9 probe saturated");
    step(1, 4'd7, 2'd2, 0, 0, 0, "R9 write at max");
    for (int i = 0; i < 7; i++) step(0, 0, 2'd0, 0, 1, 4'd7, "R6 unwind");
    step(1, 4'd1, 2'd1, 0, 0, 0, "R2 claim 1");
    step(0, 0, 2'd0, 0, 1, 4'd4, "R8 non-owner done");
    step(1, 4'd1, 2'd0, 0, 0, 0, "R5 abandon 1");
    step(0, 0, 2'd0, 0, 1, 4'd1, "R8 done at zero");
    step(1, 4'd2, 2'd0, 0, 0, 0, "R8 sticky");
    quiet();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule